// File: doc/BRIEF.md
# Three-wire serial memory fill-all controller

This block is the target-side control logic of a small serial memory of 256 bytes that is reached over a three-wire link: a select line, a serial clock and a serial data input. It samples the three pins with the system clock and parses each command frame. A frame starts with a 1 bit, which is followed by a two-bit opcode and an eight-bit address field. The block recognises three commands: write-enable, write-disable and fill-all. A fill-all that is accepted starts a self-timed sweep that first erases every byte to FF and then programs every byte with the data byte of the frame. The sweep handles one location per system clock. A settle delay of adjustable length follows, and the sweep needs no further serial clock edges.

The serial status output reports busy (low) or ready (high), but only after the select line has been held low for a minimum number of system clocks and then raised again. At all other times the output is not driven. Once the sweep has finished, a start bit followed by a drop of select clears the ready indication. The input `trig_sel` chooses the event that launches the sweep. With 0, the launch is the falling edge of select after the last data bit. With 1, the launch is the serial clock rising edge that samples the last data bit. A combinational debug port reads the storage array.

The frame parser has six states. F_IDLE moves to F_OPC on a 1 bit. F_OPC moves to F_ADDR after two bits. F_ADDR moves to F_DATA on a fill-all, and to F_SKIP for any other command. F_DATA moves to F_ARMED when `trig_sel`=0, or to F_SKIP when `trig_sel`=1. F_ARMED moves to F_IDLE on a select fall. Every state returns to F_IDLE while select is low. The sweep has four states, W_IDLE, W_ERASE, W_PROG and W_SETTLE, taken in that order, and it leaves W_IDLE only on a launch. The status unit has two states. S_HIZ moves to S_SHOW on a select rise that follows a long enough low, provided a sweep has been launched. S_SHOW moves back to S_HIZ while select is low.

Top module: `tw_fill_ctrl`

## Requirements
- R1: After reset the status output is not driven (`stat_oe`=0), writes are disabled and every array byte reads FF.
- R2: A fill-all frame (1, opcode 00, address field 01xxxxxx, then 8 data bits MSB first) that arrives while writes are disabled leaves the array unchanged.
- R3: After a write-enable frame (1, 00, address 11xxxxxx), a fill-all frame with `trig_sel`=0 sets every byte to the data byte once select falls.
- R4: With `trig_sel`=1, the serial clock rise that samples the last data bit launches the sweep, which then completes with select held high and no further serial clock edges.
- R5: With `trig_sel`=0, the array does not change while select stays high after the last data bit.
- R6: The sweep erases all bytes to FF before it programs any byte. Midway through the erase pass, byte 0 reads FF and byte 255 still holds its old value. Midway through the program pass, byte 0 holds the new data and byte 255 reads FF.
- R7: After a write-disable frame (1, 00, address 00xxxxxx), a later fill-all frame is ignored.
- R8: While a sweep runs, raising select after it has been low for at least TCSL_CYC clocks drives `stat_oe`=1 with `stat_out`=0. When the sweep ends, with select still high, `stat_out` becomes 1.
- R9: If select was low for fewer than TCSL_CYC clocks before it rises, `stat_oe` stays 0.
- R10: After the sweep has finished, a start bit followed by a drop of select clears the indication, and a later long low and rise of select leaves `stat_oe`=0.
- R11: Frames that arrive while a sweep runs, whether write-disable or fill-all, have no effect.
- R12: `stat_oe` is 0 whenever select has been low for more than the synchroniser latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_sel | input | 1 | Launch event: 0 = select fall, 1 = last data clock rise |
| sel_i | input | 1 | Serial select, active high |
| ser_clk_i | input | 1 | Serial clock |
| ser_din_i | input | 1 | Serial data in |
| stat_out | output | 1 | Ready (1) or busy (0), valid when stat_oe=1 |
| stat_oe | output | 1 | Status output driven |
| dbg_addr | input | 8 | Debug read address |
| dbg_data | output | 8 | Array byte at dbg_addr |

## Verification
If the parser counts one bit too many or too few, the opcode or data byte it assembles is misaligned. The next fill-all then leaves a wrong byte at every address of the debug port within about 530 clocks. A wrong enable flag shows up in the same window as an array that was filled when it should not have been, or left alone when it should have been filled. A fault in the status state or its low-time counter shows on `stat_oe` within three clocks of the next select rise or fall. Because of this, the bench compares the debug port and the status pins against its model on every clock.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        F_IDLE,
        F_OPC,
        F_ADDR,
        F_DATA,
        F_ARMED,
        F_SKIP
    } frame_st_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_ERASE,
        W_PROG,
        W_SETTLE
    } sweep_st_t;

    typedef enum logic {
        S_HIZ,
        S_SHOW
    } stat_st_t;

    // opcode shared by the three supported commands
    localparam logic [1:0] OPC_EXT = 2'b00;
    // first two address-field bits select the command
    localparam logic [1:0] SUB_DIS = 2'b00;
    localparam logic [1:0] SUB_ALL = 2'b01;
    localparam logic [1:0] SUB_EN  = 2'b11;

endpackage

// File: rtl/tw_pinsync.sv
module tw_pinsync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);

    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign lvl_o = stg[STAGES-1];

endmodule

// File: rtl/tw_frame.sv
module tw_frame
    import tw_pkg::*;
#(
    parameter int FRAME_AW = 8,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          di_s,
    input  logic          sck_rise,
    input  logic          cs_fall,
    input  logic          trig_sel,
    input  logic          busy,
    output logic          launch,
    output logic [DW-1:0] launch_data,
    output logic          wen,
    output logic          start_seen
);

    localparam int MAXF = (FRAME_AW > DW) ? FRAME_AW : DW;
    localparam int CW   = $clog2(MAXF + 1);

    frame_st_t     st, st_n;
    logic [CW-1:0] cnt;
    logic [1:0]    op;
    logic [1:0]    sub;
    logic [DW-1:0] dsr;
    logic          wen_n;
    logic          smp;

    assign smp = sck_rise & cs_s;

    // state register and field shifters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= F_IDLE;
            wen <= 1'b0;
            cnt <= '0;
            op  <= '0;
            sub <= '0;
            dsr <= '0;
        end else begin
            st  <= st_n;
            wen <= wen_n;
            if (st_n != st)
                cnt <= '0;
            else if (smp)
                cnt <= cnt + 1'b1;
            if (smp && st == F_OPC)
                op <= {op[0], di_s};
            if (smp && st == F_ADDR && cnt < CW'(2))
                sub <= {sub[0], di_s};
            if (smp && st == F_DATA)
                dsr <= {dsr[DW-2:0], di_s};
        end
    end

    // next state and outputs
    always_comb begin
        st_n       = st;
        wen_n      = wen;
        launch     = 1'b0;
        start_seen = 1'b0;
        unique case (st)
            F_IDLE: begin
                if (smp && di_s) begin
                    st_n       = F_OPC;
                    start_seen = 1'b1;
                end
            end
            F_OPC: begin
                if (smp && cnt == CW'(1))
                    st_n = F_ADDR;
            end
            F_ADDR: begin
                if (smp && cnt == CW'(FRAME_AW - 1)) begin
                    st_n = F_SKIP;
                    if (op == OPC_EXT) begin
                        if (sub == SUB_ALL)
                            st_n = F_DATA;
                        else if (sub == SUB_EN && !busy)
                            wen_n = 1'b1;
                        else if (sub == SUB_DIS && !busy)
                            wen_n = 1'b0;
                    end
                end
            end
            F_DATA: begin
                if (smp && cnt == CW'(DW - 1)) begin
                    if (trig_sel) begin
                        launch = wen & ~busy;
                        st_n   = F_SKIP;
                    end else begin
                        st_n   = F_ARMED;
                    end
                end
            end
            F_ARMED: begin
                if (cs_fall) begin
                    launch = wen & ~busy;
                    st_n   = F_IDLE;
                end
            end
            F_SKIP: begin
                st_n = F_SKIP;
            end
            default: st_n = F_IDLE;
        endcase
        if (!cs_s)
            st_n = F_IDLE;
    end

    assign launch_data = (st == F_DATA) ? {dsr[DW-2:0], di_s} : dsr;

endmodule

// File: rtl/tw_sweep.sv
module tw_sweep
    import tw_pkg::*;
#(
    parameter int DEPTH      = 256,
    parameter int DW         = 8,
    parameter int SETTLE_CYC = 16,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [DW-1:0] launch_data,
    input  logic [AW-1:0] dbg_addr,
    output logic [DW-1:0] dbg_data,
    output logic          busy,
    output sweep_st_t     sw_state,
    output logic [AW-1:0] sw_idx
);

    localparam int           SCW  = $clog2(SETTLE_CYC + 2);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    sweep_st_t      st_n;
    logic [AW-1:0]  idx_n;
    logic [SCW-1:0] sc, sc_n;
    logic [DW-1:0]  dat, dat_n;
    logic           we;
    logic [DW-1:0]  wd;
    logic [DW-1:0]  mem [DEPTH];

    // state register, counters and storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_state <= W_IDLE;
            sw_idx   <= '0;
            sc       <= '0;
            dat      <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            sw_state <= st_n;
            sw_idx   <= idx_n;
            sc       <= sc_n;
            dat      <= dat_n;
            if (we)
                mem[sw_idx] <= wd;
        end
    end

    // next state and write control
    always_comb begin
        st_n  = sw_state;
        idx_n = sw_idx;
        sc_n  = sc;
        dat_n = dat;
        we    = 1'b0;
        wd    = '1;
        unique case (sw_state)
            W_IDLE: begin
                if (launch) begin
                    st_n  = W_ERASE;
                    idx_n = '0;
                    dat_n = launch_data;
                end
            end
            W_ERASE: begin
                we    = 1'b1;
                wd    = '1;
                idx_n = sw_idx + 1'b1;
                if (sw_idx == LAST) begin
                    st_n  = W_PROG;
                    idx_n = '0;
                end
            end
            W_PROG: begin
                we    = 1'b1;
                wd    = dat;
                idx_n = sw_idx + 1'b1;
                if (sw_idx == LAST) begin
                    idx_n = '0;
                    sc_n  = '0;
                    st_n  = (SETTLE_CYC == 0) ? W_IDLE : W_SETTLE;
                end
            end
            W_SETTLE: begin
                sc_n = sc + 1'b1;
                if (sc == SCW'(SETTLE_CYC - 1))
                    st_n = W_IDLE;
            end
            default: st_n = W_IDLE;
        endcase
    end

    assign busy     = (sw_state != W_IDLE);
    assign dbg_data = mem[dbg_addr];

endmodule

// File: rtl/tw_status.sv
module tw_status
    import tw_pkg::*;
#(
    parameter int TCSL_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic cs_rise,
    input  logic busy,
    input  logic launch,
    input  logic start_seen,
    output logic stat_oe,
    output logic stat_out
);

    localparam int LW = $clog2(TCSL_CYC + 1);

    stat_st_t      st, st_n;
    logic          arm, arm_n;
    logic          clr, clr_n;
    logic [LW-1:0] lo;

    // state register and low-time counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= S_HIZ;
            arm <= 1'b0;
            clr <= 1'b0;
            lo  <= '0;
        end else begin
            st  <= st_n;
            arm <= arm_n;
            clr <= clr_n;
            if (cs_s)
                lo <= '0;
            else if (lo != LW'(TCSL_CYC))
                lo <= lo + 1'b1;
        end
    end

    // next state
    always_comb begin
        st_n  = st;
        arm_n = arm;
        clr_n = clr;
        unique case (st)
            S_HIZ: begin
                clr_n = 1'b0;
                if (cs_rise && lo >= LW'(TCSL_CYC) && arm)
                    st_n = S_SHOW;
            end
            S_SHOW: begin
                if (start_seen && !busy)
                    clr_n = 1'b1;
                if (!cs_s) begin
                    st_n = S_HIZ;
                    if (clr)
                        arm_n = 1'b0;
                end
            end
            default: st_n = S_HIZ;
        endcase
        if (launch)
            arm_n = 1'b1;
    end

    // outputs
    assign stat_oe  = (st == S_SHOW);
    assign stat_out = ~busy;

endmodule

// File: rtl/tw_fill_ctrl.sv
module tw_fill_ctrl
    import tw_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int DW          = 8,
    parameter int FRAME_AW    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TCSL_CYC    = 4,
    parameter int SETTLE_CYC  = 16,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_sel,
    input  logic          sel_i,
    input  logic          ser_clk_i,
    input  logic          ser_din_i,
    output logic          stat_out,
    output logic          stat_oe,
    input  logic [AW-1:0] dbg_addr,
    output logic [DW-1:0] dbg_data
);

    logic [2:0]    lvl;
    logic          cs_s, sck_s, di_s;
    logic          cs_q, sck_q;
    logic          cs_rise, cs_fall, sck_rise;
    logic          launch, wen, start_seen, busy;
    logic [DW-1:0] launch_data;
    sweep_st_t     sw_state;
    logic [AW-1:0] sw_idx;

    tw_pinsync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({sel_i, ser_clk_i, ser_din_i}),
        .lvl_o (lvl)
    );

    assign cs_s  = lvl[2];
    assign sck_s = lvl[1];
    assign di_s  = lvl[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_s;
            sck_q <= sck_s;
        end
    end

    assign cs_rise  = cs_s & ~cs_q;
    assign cs_fall  = ~cs_s & cs_q;
    assign sck_rise = sck_s & ~sck_q;

    tw_frame #(.FRAME_AW(FRAME_AW), .DW(DW)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .di_s        (di_s),
        .sck_rise    (sck_rise),
        .cs_fall     (cs_fall),
        .trig_sel    (trig_sel),
        .busy        (busy),
        .launch      (launch),
        .launch_data (launch_data),
        .wen         (wen),
        .start_seen  (start_seen)
    );

    tw_sweep #(.DEPTH(DEPTH), .DW(DW), .SETTLE_CYC(SETTLE_CYC)) u_sweep (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_data (launch_data),
        .dbg_addr    (dbg_addr),
        .dbg_data    (dbg_data),
        .busy        (busy),
        .sw_state    (sw_state),
        .sw_idx      (sw_idx)
    );

    tw_status #(.TCSL_CYC(TCSL_CYC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .cs_rise    (cs_rise),
        .busy       (busy),
        .launch     (launch),
        .start_seen (start_seen),
        .stat_oe    (stat_oe),
        .stat_out   (stat_out)
    );

endmodule

// File: rtl/tw_fill_chk.sv
module tw_fill_chk
    import tw_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_s,
    input logic          busy,
    input logic          wen,
    input logic          stat_oe,
    input sweep_st_t     sw_state,
    input logic [AW-1:0] sw_idx
);

    // R12: deselect forces the status output undriven one cycle later
    assert_hiz_deselected_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !stat_oe);

    // R2: a sweep only starts out of the write-enabled state
    assert_launch_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen));

    // R11: frames during a sweep do not touch the enable state
    assert_enable_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wen));

    // R4: the erase pass advances every system clock, with no serial clock needed
    assert_sweep_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_state == W_ERASE && $past(sw_state) == W_ERASE) |-> sw_idx == AW'($past(sw_idx) + 1'b1));

    // R6: programming is entered only from a finished erase pass
    assert_erase_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_state == W_PROG) |-> $past(sw_state) == W_ERASE);

endmodule

bind tw_fill_ctrl tw_fill_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .busy     (busy),
    .wen      (wen),
    .stat_oe  (stat_oe),
    .sw_state (sw_state),
    .sw_idx   (sw_idx)
);

// File: tb/test_tw_fill_ctrl.sv
module test_tw_fill_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int SWEEP_WAIT = 700;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_sel = 1'b0;
    logic       sel_i = 1'b0;
    logic       ser_clk_i = 1'b0;
    logic       ser_din_i = 1'b0;
    logic       stat_out;
    logic       stat_oe;
    logic [7:0] dbg_addr = 8'd0;
    logic [7:0] dbg_data;

    int         n_chk = 0;
    int         n_fail = 0;
    int         lowrun = 0;
    bit         model_ok = 1'b0;
    bit         hold_dbg = 1'b0;
    string      cur_req = "R1";
    logic [7:0] model_mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_fill_ctrl i_tw_fill_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_sel  (trig_sel),
        .sel_i     (sel_i),
        .ser_clk_i (ser_clk_i),
        .ser_din_i (ser_din_i),
        .stat_out  (stat_out),
        .stat_oe   (stat_oe),
        .dbg_addr  (dbg_addr),
        .dbg_data  (dbg_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic set_model(input logic [7:0] v);
        for (int i = 0; i < 256; i++) model_mem[i] = v;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_din_i = b;
        wait_clk(HALF);
        ser_clk_i = 1'b1;
        wait_clk(HALF);
        ser_clk_i = 1'b0;
    endtask

    task automatic frame(input logic [7:0] addr, input logic [7:0] data,
                         input bit has_data, input bit drop);
        @(negedge clk);
        sel_i = 1'b1;
        wait_clk(4);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b0);
        for (int i = 7; i >= 0; i--) send_bit(addr[i]);
        if (has_data)
            for (int i = 7; i >= 0; i--) send_bit(data[i]);
        if (drop) begin
            wait_clk(4);
            sel_i = 1'b0;
            wait_clk(8);
        end
    endtask

    task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        dbg_addr = a;
        #1;
        chk(dbg_data === exp, req, dbg_data, exp);
    endtask

    // debug address scan
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (!hold_dbg) dbg_addr = dbg_addr + 8'd1;
        end
    end

    // per-clock comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sel_i === 1'b0) lowrun++; else lowrun = 0;
            if (rst_n && lowrun >= 6)
                chk(stat_oe === 1'b0, "R12", stat_oe, 0);
            if (rst_n && model_ok && !hold_dbg)
                chk(dbg_data === model_mem[dbg_addr], cur_req, dbg_data, model_mem[dbg_addr]);
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        set_model(8'hFF);
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: reset state
        chk(stat_oe === 1'b0, "R1", stat_oe, 0);
        cur_req  = "R1";
        model_ok = 1'b1;
        wait_clk(300);

        // R2: fill-all while disabled is ignored
        cur_req = "R2";
        frame(8'h7F, 8'h5A, 1'b1, 1'b1);
        wait_clk(SWEEP_WAIT);

        // enable, then R5 / R3 with select-fall launch
        frame(8'hD5, 8'h00, 1'b0, 1'b1);
        cur_req = "R5";
        frame(8'h6B, 8'h5A, 1'b1, 1'b0);
        wait_clk(300);
        model_ok = 1'b0;
        sel_i = 1'b0;
        wait_clk(SWEEP_WAIT);
        set_model(8'h5A);
        cur_req  = "R3";
        model_ok = 1'b1;
        wait_clk(300);

        // R6: erase precedes programming
        model_ok = 1'b0;
        frame(8'h40, 8'hC3, 1'b1, 1'b1);
        hold_dbg = 1'b1;
        wait_clk(120);
        peek(8'd0,   8'hFF, "R6");
        peek(8'd255, 8'h5A, "R6");
        wait_clk(254);
        peek(8'd0,   8'hC3, "R6");
        peek(8'd255, 8'hFF, "R6");
        hold_dbg = 1'b0;
        wait_clk(SWEEP_WAIT);
        set_model(8'hC3);
        cur_req  = "R6";
        model_ok = 1'b1;
        wait_clk(300);

        // R4: clock-edge launch, completion with select high and no serial clock
        trig_sel = 1'b1;
        model_ok = 1'b0;
        frame(8'h55, 8'h3C, 1'b1, 1'b0);
        wait_clk(SWEEP_WAIT);
        set_model(8'h3C);
        cur_req  = "R4";
        model_ok = 1'b1;
        wait_clk(300);
        sel_i = 1'b0;
        wait_clk(8);

        // R8 / R9 / R10: status output sequencing
        trig_sel = 1'b0;
        model_ok = 1'b0;
        frame(8'h40, 8'h96, 1'b1, 1'b1);
        sel_i = 1'b1;
        wait_clk(6);
        chk(stat_oe === 1'b1, "R8", stat_oe, 1);
        chk(stat_out === 1'b0, "R8", stat_out, 0);
        sel_i = 1'b0;
        wait_clk(2);
        sel_i = 1'b1;
        wait_clk(6);
        chk(stat_oe === 1'b0, "R9", stat_oe, 0);
        sel_i = 1'b0;
        wait_clk(8);
        sel_i = 1'b1;
        wait_clk(6);
        chk(stat_oe === 1'b1, "R8", stat_oe, 1);
        chk(stat_out === 1'b0, "R8", stat_out, 0);
        wait_clk(SWEEP_WAIT);
        chk(stat_oe === 1'b1, "R8", stat_oe, 1);
        chk(stat_out === 1'b1, "R8", stat_out, 1);
        set_model(8'h96);
        cur_req  = "R8";
        model_ok = 1'b1;
        send_bit(1'b1);
        wait_clk(2);
        sel_i = 1'b0;
        wait_clk(8);
        sel_i = 1'b1;
        wait_clk(6);
        chk(stat_oe === 1'b0, "R10", stat_oe, 0);
        sel_i = 1'b0;
        wait_clk(8);

        // R11: frames during a sweep are ignored
        trig_sel = 1'b1;
        model_ok = 1'b0;
        frame(8'h40, 8'h11, 1'b1, 1'b1);
        frame(8'h00, 8'h00, 1'b0, 1'b1);
        frame(8'h40, 8'h77, 1'b1, 1'b1);
        wait_clk(SWEEP_WAIT);
        set_model(8'h11);
        cur_req  = "R11";
        model_ok = 1'b1;
        wait_clk(300);
        model_ok = 1'b0;
        frame(8'h40, 8'h22, 1'b1, 1'b1);
        wait_clk(SWEEP_WAIT);
        set_model(8'h22);
        model_ok = 1'b1;
        wait_clk(300);

        // R7: disable blocks a later fill-all
        cur_req = "R7";
        frame(8'h2A, 8'h00, 1'b0, 1'b1);
        frame(8'h40, 8'h44, 1'b1, 1'b1);
        wait_clk(SWEEP_WAIT);

        finish_run();
    end

endmodule